// File: doc/BRIEF.md
# Extended-Mode Interrupt Vector Injector

This block sits on the program-fetch path in front of an 8051-class core. It turns the two fixed external-interrupt entry points into one jump per interrupt source. A mode register selects between two behaviours:

- **Basic mode:** fetched bytes pass through untouched, and software works out which source raised the interrupt.
- **Extended mode:** the core's hardware call lands on the INT0 entry (0x0003) or the INT1 entry (0x0013). The block then replaces the next three fetched bytes with a long jump whose target comes from a table of 16-bit vector registers.

The table is written over the SFR write port and is shared by both channels. The entry used is chosen by the highest-ranked pending source of the calling channel. When that channel is edge-triggered, the block also gives the status aggregator a one-cycle, one-hot clear for the serviced source bit.

Each source has a rank that matches its bit index in the pending and clear vectors:

| Bit | Source |
|-----|--------|
| 7 | PLL |
| 6 | HW1 |
| 5 | clock-stop |
| 4 | HW2 |
| 3 | debug |
| 2 | HW3 |
| 1 | HW4 |
| 0 | analog |

All outputs are registered. A fetch strobed in one cycle has its override visible after the next rising edge.

Top module: `xvec_injector`

## Requirements
- R1: Synchronous reset clears `ovr_valid`, `ovr_byte`, both clear outputs, every vector register (to 0x0000) and the mode bit (to basic mode).
- R2: In basic mode a strobed fetch of either entry address produces no override and no clear, whatever is pending.
- R3: In extended mode a strobed fetch of 0x0003 with `ch0_pend` non-zero drives `ovr_valid`=1 and `ovr_byte`=0x02 in the following cycle. The next strobed fetches of 0x0004 and 0x0005 then return the selected vector's high byte and then its low byte, each with `ovr_valid`=1.
- R4: INT1 behaves the same way at 0x0013, 0x0014 and 0x0015, selecting from `ch1_pend`, and uses the same vector table as INT0.
- R5: When several bits of the calling channel's pending vector are set, the highest bit index is serviced.
- R6: Each source's low vector byte sits at an SFR address and its high byte at that address plus one. Bit 7 uses 0xA4, bit 6 0xA6, bit 5 0xAC, bit 4 0xAE, bit 3 0xB4, bit 2 0xB6, bit 1 0xBC and bit 0 0xBE.
- R7: When the calling channel's edge input is 1, the opcode byte is accompanied by a one-cycle pulse on that channel's clear output at the serviced bit only. When it is 0, no clear is issued. The other channel's clear output stays zero.
- R8: The serviced source is latched at the entry fetch. A change of the pending inputs during the sequence does not alter the emitted vector bytes.
- R9: An entry fetch in extended mode with no pending bit on that channel produces no override.
- R10: If the fetch after the opcode (or after the high byte) is not at the next consecutive address, the sequence is abandoned. That fetch and the later ones receive no override until a new entry fetch.
- R11: The mode is bit 2 of SFR 0x9B (1 = extended). The other bits of that byte, and writes to other addresses outside the vector table, do not change the mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_we | input | 1 | SFR write enable |
| sfr_addr | input | 8 | SFR write address |
| sfr_wdata | input | 8 | SFR write data |
| fetch_addr | input | 16 | Program fetch address |
| fetch_stb | input | 1 | Fetch strobe, one cycle per fetched byte |
| ch0_pend | input | 8 | Unmasked pending sources routed to INT0 |
| ch1_pend | input | 8 | Unmasked pending sources routed to INT1 |
| ch0_edge | input | 1 | INT0 is edge-triggered |
| ch1_edge | input | 1 | INT1 is edge-triggered |
| ovr_valid | output | 1 | Replace the fetched byte with `ovr_byte` |
| ovr_byte | output | 8 | Substitute instruction byte |
| ch0_clr | output | 8 | One-hot clear of a serviced INT0 source |
| ch1_clr | output | 8 | One-hot clear of a serviced INT1 source |

## Verification
The checker assumes that the pending and edge inputs are valid in the same cycle as the strobed entry fetch, since it compares each clear pulse against those inputs one cycle earlier. It also assumes that every override byte answers a strobe in the previous cycle. The bench drives all inputs on falling edges and holds them across the fetch edge. It raises pending bits only on the channel whose entry it fetches, so each clear can be attributed to a single source. In the latching test, it changes the pending inputs only after the opcode byte has been emitted.

// File: rtl/xvi_pkg.sv
package xvi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HI, ST_LO} seq_st_t;

  // Low-byte SFR address of the vector for rank k (0 = highest-ranked source).
  function automatic logic [7:0] vec_lo_addr(input int unsigned k);
    logic [2:0] kk;
    kk = k[2:0];
    return 8'hA4 + (kk[2] ? 8'h10 : 8'h00) + (kk[1] ? 8'h08 : 8'h00)
                 + (kk[0] ? 8'h02 : 8'h00);
  endfunction
endpackage

// File: rtl/xvi_vec_table.sv
module xvi_vec_table #(
  parameter int NSRC = 8,
  parameter int DW   = 8,
  parameter int SAW  = 8,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SAW-1:0]  addr,
  input  logic [DW-1:0]   wdata,
  input  logic [IW-1:0]   rd_idx,
  output logic [2*DW-1:0] rd_word
);
  logic [2*DW-1:0] tbl [NSRC];

  for (genvar i = 0; i < NSRC; i++) begin : g_ent
    localparam logic [SAW-1:0] LO_A = SAW'(xvi_pkg::vec_lo_addr(NSRC - 1 - i));
    localparam logic [SAW-1:0] HI_A = LO_A + SAW'(1);
    always_ff @(posedge clk) begin
      if (rst) begin
        tbl[i] <= '0;
      end else if (we) begin
        if (addr == LO_A) tbl[i][DW-1:0]    <= wdata;
        if (addr == HI_A) tbl[i][2*DW-1:DW] <= wdata;
      end
    end
  end

  assign rd_word = tbl[rd_idx];
endmodule

// File: rtl/xvi_prio_pick.sv
module xvi_prio_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx    = '0;
    onehot = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        idx    = IW'(i);
        onehot = N'(1) << i;
      end
    end
    any = |req;
  end
endmodule

// File: rtl/xvi_seq.sv
module xvi_seq #(
  parameter int          NSRC   = 8,
  parameter int          AW     = 16,
  parameter int          DW     = 8,
  parameter logic [15:0] ENTRY0 = 16'h0003,
  parameter logic [15:0] ENTRY1 = 16'h0013,
  parameter logic [7:0]  JMP_OP = 8'h02,
  localparam int         IW     = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode_ext,
  input  logic            fetch_stb,
  input  logic [AW-1:0]   fetch_addr,
  input  logic            any0,
  input  logic [IW-1:0]   idx0,
  input  logic [NSRC-1:0] oh0,
  input  logic            edge0,
  input  logic            any1,
  input  logic [IW-1:0]   idx1,
  input  logic [NSRC-1:0] oh1,
  input  logic            edge1,
  input  logic [2*DW-1:0] vec_word,
  output logic [IW-1:0]   sel_idx,
  output logic            ovr_valid,
  output logic [DW-1:0]   ovr_byte,
  output logic [NSRC-1:0] clr0,
  output logic [NSRC-1:0] clr1
);
  import xvi_pkg::*;

  localparam logic [AW-1:0] E0 = AW'(ENTRY0);
  localparam logic [AW-1:0] E1 = AW'(ENTRY1);

  seq_st_t       st;
  logic          ch_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base;

  assign base    = ch_q ? E1 : E0;
  assign sel_idx = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ch_q      <= 1'b0;
      idx_q     <= '0;
      ovr_valid <= 1'b0;
      ovr_byte  <= '0;
      clr0      <= '0;
      clr1      <= '0;
    end else begin
      ovr_valid <= 1'b0;
      clr0      <= '0;
      clr1      <= '0;
      if (fetch_stb) begin
        unique case (st)
          ST_IDLE: begin
            if (mode_ext && fetch_addr == E0 && any0) begin
              ch_q      <= 1'b0;
              idx_q     <= idx0;
              ovr_valid <= 1'b1;
              ovr_byte  <= DW'(JMP_OP);
              st        <= ST_HI;
              if (edge0) clr0 <= oh0;
            end else if (mode_ext && fetch_addr == E1 && any1) begin
              ch_q      <= 1'b1;
              idx_q     <= idx1;
              ovr_valid <= 1'b1;
              ovr_byte  <= DW'(JMP_OP);
              st        <= ST_HI;
              if (edge1) clr1 <= oh1;
            end
          end
          ST_HI: begin
            if (fetch_addr == base + AW'(1)) begin
              ovr_valid <= 1'b1;
              ovr_byte  <= vec_word[2*DW-1:DW];
              st        <= ST_LO;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_LO: begin
            if (fetch_addr == base + AW'(2)) begin
              ovr_valid <= 1'b1;
              ovr_byte  <= vec_word[DW-1:0];
            end
            st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/xvec_injector.sv
module xvec_injector #(
  parameter int          NSRC      = 8,
  parameter int          AW        = 16,
  parameter int          DW        = 8,
  parameter int          SAW       = 8,
  parameter logic [7:0]  MODE_ADDR = 8'h9B,
  parameter int          MODE_BIT  = 2,
  parameter logic [15:0] ENTRY0    = 16'h0003,
  parameter logic [15:0] ENTRY1    = 16'h0013,
  parameter logic [7:0]  JMP_OP    = 8'h02,
  localparam int         IW        = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sfr_we,
  input  logic [SAW-1:0]  sfr_addr,
  input  logic [DW-1:0]   sfr_wdata,
  input  logic [AW-1:0]   fetch_addr,
  input  logic            fetch_stb,
  input  logic [NSRC-1:0] ch0_pend,
  input  logic [NSRC-1:0] ch1_pend,
  input  logic            ch0_edge,
  input  logic            ch1_edge,
  output logic            ovr_valid,
  output logic [DW-1:0]   ovr_byte,
  output logic [NSRC-1:0] ch0_clr,
  output logic [NSRC-1:0] ch1_clr
);
  logic            mode_q;
  logic            any0, any1;
  logic [IW-1:0]   idx0, idx1, sel_idx;
  logic [NSRC-1:0] oh0, oh1;
  logic [2*DW-1:0] vec_word;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (sfr_we && sfr_addr == SAW'(MODE_ADDR)) mode_q <= sfr_wdata[MODE_BIT];
  end

  xvi_vec_table #(.NSRC(NSRC), .DW(DW), .SAW(SAW)) u_tbl (
    .clk(clk), .rst(rst), .we(sfr_we), .addr(sfr_addr), .wdata(sfr_wdata),
    .rd_idx(sel_idx), .rd_word(vec_word)
  );

  xvi_prio_pick #(.N(NSRC)) u_pick0 (.req(ch0_pend), .any(any0), .idx(idx0), .onehot(oh0));
  xvi_prio_pick #(.N(NSRC)) u_pick1 (.req(ch1_pend), .any(any1), .idx(idx1), .onehot(oh1));

  xvi_seq #(
    .NSRC(NSRC), .AW(AW), .DW(DW),
    .ENTRY0(ENTRY0), .ENTRY1(ENTRY1), .JMP_OP(JMP_OP)
  ) u_seq (
    .clk(clk), .rst(rst), .mode_ext(mode_q),
    .fetch_stb(fetch_stb), .fetch_addr(fetch_addr),
    .any0(any0), .idx0(idx0), .oh0(oh0), .edge0(ch0_edge),
    .any1(any1), .idx1(idx1), .oh1(oh1), .edge1(ch1_edge),
    .vec_word(vec_word), .sel_idx(sel_idx),
    .ovr_valid(ovr_valid), .ovr_byte(ovr_byte),
    .clr0(ch0_clr), .clr1(ch1_clr)
  );
endmodule

// File: rtl/xvec_injector_chk.sv
module xvec_injector_chk #(
  parameter int         NSRC   = 8,
  parameter int         DW     = 8,
  parameter logic [7:0] JMP_OP = 8'h02
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_stb,
  input logic [NSRC-1:0] ch0_pend,
  input logic [NSRC-1:0] ch1_pend,
  input logic            ch0_edge,
  input logic            ch1_edge,
  input logic            ovr_valid,
  input logic [DW-1:0]   ovr_byte,
  input logic [NSRC-1:0] ch0_clr,
  input logic [NSRC-1:0] ch1_clr
);
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch0_clr) && $onehot0(ch1_clr)); // R7

  AST_CLR_ONE_CH: assert property (@(posedge clk) disable iff (rst)
    !((|ch0_clr) && (|ch1_clr))); // R7

  AST_CLR_WITH_OPCODE: assert property (@(posedge clk) disable iff (rst)
    ((|ch0_clr) || (|ch1_clr)) |-> (ovr_valid && ovr_byte == DW'(JMP_OP))); // R7

  AST_CLR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    ((|ch0_clr) |-> $past(ch0_edge)) and ((|ch1_clr) |-> $past(ch1_edge))); // R7

  AST_OVR_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
    ovr_valid |-> $past(fetch_stb)); // R3

  AST_PRIO_TOP0: assert property (@(posedge clk) disable iff (rst)
    (|ch0_clr) |-> (((ch0_clr & $past(ch0_pend)) == ch0_clr)
      && (($past(ch0_pend) & ~((ch0_clr << 1) - NSRC'(1))) == '0))); // R5

  AST_PRIO_TOP1: assert property (@(posedge clk) disable iff (rst)
    (|ch1_clr) |-> (((ch1_clr & $past(ch1_pend)) == ch1_clr)
      && (($past(ch1_pend) & ~((ch1_clr << 1) - NSRC'(1))) == '0))); // R5
endmodule

bind xvec_injector xvec_injector_chk #(.NSRC(NSRC), .DW(DW), .JMP_OP(JMP_OP)) u_chk (
  .clk(clk), .rst(rst), .fetch_stb(fetch_stb),
  .ch0_pend(ch0_pend), .ch1_pend(ch1_pend),
  .ch0_edge(ch0_edge), .ch1_edge(ch1_edge),
  .ovr_valid(ovr_valid), .ovr_byte(ovr_byte),
  .ch0_clr(ch0_clr), .ch1_clr(ch1_clr)
);

// File: tb/xvec_injector_tb.sv
module xvec_injector_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_addr = '0;
  logic [7:0]  sfr_wdata = '0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_stb = 1'b0;
  logic [7:0]  ch0_pend = '0;
  logic [7:0]  ch1_pend = '0;
  logic        ch0_edge = 1'b0;
  logic        ch1_edge = 1'b0;
  logic        ovr_valid;
  logic [7:0]  ovr_byte;
  logic [7:0]  ch0_clr;
  logic [7:0]  ch1_clr;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  xvec_injector dut_i (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
    .fetch_addr(fetch_addr), .fetch_stb(fetch_stb),
    .ch0_pend(ch0_pend), .ch1_pend(ch1_pend), .ch0_edge(ch0_edge), .ch1_edge(ch1_edge),
    .ovr_valid(ovr_valid), .ovr_byte(ovr_byte), .ch0_clr(ch0_clr), .ch1_clr(ch1_clr)
  );

  // R6: low-byte address per source bit index
  localparam logic [7:0] LADDR [8] = '{8'hBE, 8'hBC, 8'hB6, 8'hB4, 8'hAE, 8'hAC, 8'hA6, 8'hA4};

  // {channel, edge, pending, expected source}
  localparam logic [13:0] VT [9] = '{
    {1'b0, 1'b1, 8'h01, 4'd0},
    {1'b0, 1'b1, 8'h81, 4'd7},
    {1'b0, 1'b0, 8'h18, 4'd4},
    {1'b1, 1'b1, 8'h06, 4'd2},
    {1'b1, 1'b0, 8'h40, 4'd6},
    {1'b1, 1'b1, 8'hFF, 4'd7},
    {1'b0, 1'b1, 8'h28, 4'd5},
    {1'b1, 1'b1, 8'h08, 4'd3},
    {1'b0, 1'b0, 8'h02, 4'd1}
  };

  function automatic logic [7:0] vhi(input int i); return 8'hC0 + 8'(i); endfunction
  function automatic logic [7:0] vlo(input int i); return 8'h50 + 8'(3 * i); endfunction

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(posedge clk); @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic do_fetch(input logic [15:0] a);
    fetch_addr = a; fetch_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    fetch_stb = 1'b0;
  endtask

  task automatic run_entry(input bit ch, input bit edg, input logic [7:0] pend, input int src, input string req);
    logic [15:0] e;
    logic [7:0]  exp_clr;
    e = ch ? 16'h0013 : 16'h0003;
    exp_clr = edg ? (8'h01 << src) : 8'h00;
    ch0_pend = ch ? 8'h00 : pend;
    ch1_pend = ch ? pend : 8'h00;
    ch0_edge = edg; ch1_edge = edg;
    do_fetch(e);
    chk(req, "opcode valid", 16'(ovr_valid), 16'h1);
    chk(req, "opcode byte", 16'(ovr_byte), 16'h02);
    chk("R7", "serviced clear", 16'(ch ? ch1_clr : ch0_clr), 16'(exp_clr));
    chk("R7", "other clear", 16'(ch ? ch0_clr : ch1_clr), 16'h0);
    do_fetch(e + 16'd1);
    chk("R7", "clear is one cycle", 16'(ch0_clr | ch1_clr), 16'h0);
    chk(req, "high byte", {7'b0, ovr_valid, ovr_byte}, {8'h01, vhi(src)});
    do_fetch(e + 16'd2);
    chk(req, "low byte", {7'b0, ovr_valid, ovr_byte}, {8'h01, vlo(src)});
    ch0_pend = '0; ch1_pend = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "reset outputs", {7'b0, ovr_valid, ovr_byte}, 16'h0);
    chk("R1", "reset clears", {ch0_clr, ch1_clr}, 16'h0);

    // R2 / R1: basic mode after reset, nothing substituted
    ch0_pend = 8'h01; ch0_edge = 1'b1;
    do_fetch(16'h0003);
    chk("R2", "basic mode INT0 no override", 16'(ovr_valid), 16'h0);
    chk("R2", "basic mode no clear", 16'(ch0_clr), 16'h0);
    ch1_pend = 8'h80;
    do_fetch(16'h0013);
    chk("R2", "basic mode INT1 no override", 16'(ovr_valid), 16'h0);
    ch1_pend = '0;

    // R11 / R1: enter extended mode; vectors read back as reset value
    sfr_write(8'h9B, 8'h04);
    do_fetch(16'h0003);
    chk("R11", "extended mode opcode", {7'b0, ovr_valid, ovr_byte}, 16'h0102);
    do_fetch(16'h0004);
    chk("R1", "reset vector high", {7'b0, ovr_valid, ovr_byte}, 16'h0100);
    do_fetch(16'h0005);
    chk("R1", "reset vector low", {7'b0, ovr_valid, ovr_byte}, 16'h0100);
    ch0_pend = '0;

    // R6: program vector table
    for (int i = 0; i < 8; i++) begin
      sfr_write(LADDR[i], vlo(i));
      sfr_write(LADDR[i] + 8'd1, vhi(i));
    end

    // R3 R4 R5 R6 R7: table walk
    for (int k = 0; k < 9; k++) begin
      run_entry(VT[k][13], VT[k][12], VT[k][11:4], int'(VT[k][3:0]),
                VT[k][13] ? "R4" : "R3");
    end
    run_entry(1'b0, 1'b1, 8'h12, 4, "R5");
    run_entry(1'b1, 1'b1, 8'h12, 4, "R4");

    // R8: selection latched at entry fetch
    ch0_pend = 8'h01; ch0_edge = 1'b1;
    do_fetch(16'h0003);
    chk("R8", "opcode", 16'(ovr_byte), 16'h02);
    ch0_pend = 8'h80;
    do_fetch(16'h0004);
    chk("R8", "high byte latched source", 16'(ovr_byte), 16'(vhi(0)));
    ch0_pend = 8'h40;
    do_fetch(16'h0005);
    chk("R8", "low byte latched source", 16'(ovr_byte), 16'(vlo(0)));
    ch0_pend = '0;

    // R9: no pending source
    do_fetch(16'h0003);
    chk("R9", "INT0 no pending", 16'(ovr_valid), 16'h0);
    do_fetch(16'h0013);
    chk("R9", "INT1 no pending", 16'(ovr_valid), 16'h0);

    // R10: broken sequence abandoned
    ch0_pend = 8'h04;
    do_fetch(16'h0003);
    chk("R10", "opcode before break", 16'(ovr_valid), 16'h1);
    ch0_pend = '0;
    do_fetch(16'h0100);
    chk("R10", "non-consecutive fetch", 16'(ovr_valid), 16'h0);
    do_fetch(16'h0004);
    chk("R10", "after abandon", 16'(ovr_valid), 16'h0);
    ch1_pend = 8'h20;
    do_fetch(16'h0013);
    do_fetch(16'h0014);
    chk("R10", "high byte before break", {7'b0, ovr_valid, ovr_byte}, {8'h01, vhi(5)});
    do_fetch(16'h0016);
    chk("R10", "wrong low address", 16'(ovr_valid), 16'h0);
    ch1_pend = '0;

    // R11: only bit 2 of 0x9B sets the mode
    sfr_write(8'h9A, 8'h00);
    sfr_write(8'hA8, 8'h00);
    ch0_pend = 8'h01;
    do_fetch(16'h0003);
    chk("R11", "other addresses keep mode", 16'(ovr_valid), 16'h1);
    do_fetch(16'h0004); do_fetch(16'h0005);
    sfr_write(8'h9B, 8'hFB);
    do_fetch(16'h0003);
    chk("R11", "bit 2 clear gives basic mode", 16'(ovr_valid), 16'h0);
    sfr_write(8'h9B, 8'h04);
    do_fetch(16'h0003);
    chk("R11", "bit 2 set gives extended mode", 16'(ovr_valid), 16'h1);
    do_fetch(16'h0004);
    chk("R6", "vector survives unrelated writes", 16'(ovr_byte), 16'(vhi(0)));
    do_fetch(16'h0005);
    ch0_pend = '0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule